// File: doc/BRIEF.md
# Compute-Unit Thread-Block Dispatcher

This block feeds thread blocks to a set of compute cores on behalf of a partitioning unit. A status entry for each core records its state (idle, awaiting configuration, running, or reserved), the kernel it serves, the kernel it is reserved for, and how many of its blocks are in flight. The partitioner posts one event at a time. An event either assigns an idle core to a kernel, or reserves a running core for a different kernel. Each core raises a completion pulse whenever one of its blocks retires.

A small kernel table holds, for each kernel slot, the number of blocks still to launch, a per-core limit on blocks in flight, and the setup data. The setup data is a context id, a page-table base, a texture-table base and an entry program counter. Each cycle, a round-robin arbiter picks one core that needs service and performs a single action for it. The action is one of: configure the core, issue one block, release the core and report that its kernel has drained, or switch a drained reserved core to its recorded next kernel. All outputs are registered, so an action decided in a cycle appears on the ports after the following clock edge.

Top module: `blk_dispatch`

## Requirements
- R1: While reset is high and in the cycle after it falls, issue_valid, cfg_valid and fin_valid are low and every core is idle.
- R2: An assign event (part_reserve=0) to an idle core moves it to configuration. The core is served with one cfg_valid pulse carrying its kernel's context id, page-table base, texture base and program counter. The core issues no block before that pulse.
- R3: A running core whose kernel has blocks left to launch, and whose in-flight count is below the kernel's limit, is served with an issue_valid pulse. The pulse gives the core, the kernel and a block index equal to the remaining count minus one. The remaining count then drops by one.
- R4: A running core whose in-flight count has reached the kernel's per-core limit issues nothing until a completion lowers the count.
- R5: A running core whose kernel has no blocks left and whose in-flight count is zero is released to idle. A fin_valid pulse gives the core and the kernel.
- R6: A reserve event (part_reserve=1) to a running core marks it reserved for part_kern. A reserved core issues nothing. Once its in-flight count is zero, it switches to the recorded kernel, is configured as in R2, and then issues from that kernel.
- R7: At most one of issue_valid, cfg_valid and fin_valid is high in any cycle. Among cores needing service, the grant rotates round-robin, starting after the last granted core. A core named by a partition event in a cycle is not served in that cycle.
- R8: Each done_i bit lowers that core's in-flight count by one in the same cycle. This holds when several bits are set at once and when the completion coincides with an issue to that core. A completion must never arrive at a count of zero.
- R9: An assign event to a core that is not idle, and a reserve event to a core that is not running, are ignored.
- R10: A kernel load (kld_valid) replaces the slot's remaining count, limit and setup data. It overrides a same-cycle issue decrement on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| part_valid | input | 1 | Partition event strobe |
| part_reserve | input | 1 | 0 = assign idle core, 1 = reserve running core |
| part_sm | input | 2 | Core named by the event |
| part_kern | input | 2 | Kernel slot named by the event |
| done_i | input | 4 | One completion pulse per core |
| kld_valid | input | 1 | Kernel table load strobe |
| kld_kern | input | 2 | Kernel slot to load |
| kld_blocks | input | 8 | Blocks to launch |
| kld_limit | input | 5 | Per-core in-flight limit |
| kld_ctx | input | 4 | Context id |
| kld_pt | input | 16 | Page-table base |
| kld_tex | input | 16 | Texture-table base |
| kld_pc | input | 16 | Entry program counter |
| issue_valid | output | 1 | Block issue strobe |
| issue_sm | output | 2 | Target core |
| issue_kern | output | 2 | Kernel of the block |
| issue_blk | output | 8 | Block index |
| cfg_valid | output | 1 | Core setup strobe |
| cfg_sm | output | 2 | Core being set up |
| cfg_ctx | output | 4 | Context id register value |
| cfg_pt | output | 16 | Page-table base register value |
| cfg_tex | output | 16 | Texture-table base register value |
| cfg_pc | output | 16 | Program counter |
| fin_valid | output | 1 | Kernel drained on a core |
| fin_sm | output | 2 | Released core |
| fin_kern | output | 2 | Kernel that drained |

## Verification
Two cores are first driven into the limit with no completions, which separates a correct per-core stall from free-running issue. A single cycle with completions on both cores then shows that simultaneous retirements each free one slot. Four cores on three kernels with random completions stress the round-robin rotation and the interleaving of setup, issue and release. Events aimed at cores in the wrong state must leave the output stream unchanged. A reservation on a busy core must hold back issue until the drain finishes, followed by a fresh setup pulse for the new kernel.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;

    localparam int SM_N     = 4;
    localparam int KERN_N   = 4;
    localparam int BLK_W    = 8;
    localparam int RUN_W    = 5;
    localparam int CTX_W    = 4;
    localparam int ADDR_W   = 16;
    localparam int SM_IDX_W = $clog2(SM_N);
    localparam int KIDX_W   = $clog2(KERN_N);

    typedef enum logic [1:0] {
        SM_IDLE = 2'd0,
        SM_CFG  = 2'd1,
        SM_RUN  = 2'd2,
        SM_RESV = 2'd3
    } sm_state_e;

    typedef struct packed {
        sm_state_e          st;
        logic [KIDX_W-1:0]  kern;
        logic [KIDX_W-1:0]  nxt;
        logic [RUN_W-1:0]   cnt;
    } sm_entry_t;

    typedef struct packed {
        logic [BLK_W-1:0]   pend;
        logic [RUN_W-1:0]   lim;
        logic [CTX_W-1:0]   ctx;
        logic [ADDR_W-1:0]  pt;
        logic [ADDR_W-1:0]  tex;
        logic [ADDR_W-1:0]  pc;
    } kern_entry_t;

    function automatic logic [SM_IDX_W-1:0] rr_next(input logic [SM_IDX_W-1:0] idx);
        return (int'(idx) == SM_N - 1) ? '0 : idx + 1'b1;
    endfunction

endpackage

// File: rtl/blk_dispatch_arb.sv
module blk_dispatch_arb
    import blk_dispatch_pkg::*;
#(
    parameter int N = SM_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    output logic                 gnt_valid,
    output logic [SM_IDX_W-1:0]  gnt_idx
);
    logic [SM_IDX_W-1:0] ptr_q;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(ptr_q) + k) % N;
            if (req[j]) begin
                gnt_valid = 1'b1;
                gnt_idx   = SM_IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            ptr_q <= '0;
        else if (gnt_valid) ptr_q <= rr_next(gnt_idx);
    end
endmodule

// File: rtl/blk_dispatch_ktable.sv
module blk_dispatch_ktable
    import blk_dispatch_pkg::*;
#(
    parameter int KN = KERN_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_valid,
    input  logic [KIDX_W-1:0]  ld_idx,
    input  kern_entry_t        ld_ent,
    input  logic               dec_valid,
    input  logic [KIDX_W-1:0]  dec_idx,
    output kern_entry_t        ents [KN]
);
    genvar g;
    generate
        for (g = 0; g < KN; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    ents[g] <= '0;
                end else if (ld_valid && int'(ld_idx) == g) begin
                    ents[g] <= ld_ent;
                end else if (dec_valid && int'(dec_idx) == g) begin
                    ents[g].pend <= ents[g].pend - 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
    import blk_dispatch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 part_valid,
    input  logic                 part_reserve,
    input  logic [SM_IDX_W-1:0]  part_sm,
    input  logic [KIDX_W-1:0]    part_kern,
    input  logic [SM_N-1:0]      done_i,
    input  logic                 kld_valid,
    input  logic [KIDX_W-1:0]    kld_kern,
    input  logic [BLK_W-1:0]     kld_blocks,
    input  logic [RUN_W-1:0]     kld_limit,
    input  logic [CTX_W-1:0]     kld_ctx,
    input  logic [ADDR_W-1:0]    kld_pt,
    input  logic [ADDR_W-1:0]    kld_tex,
    input  logic [ADDR_W-1:0]    kld_pc,
    output logic                 issue_valid,
    output logic [SM_IDX_W-1:0]  issue_sm,
    output logic [KIDX_W-1:0]    issue_kern,
    output logic [BLK_W-1:0]     issue_blk,
    output logic                 cfg_valid,
    output logic [SM_IDX_W-1:0]  cfg_sm,
    output logic [CTX_W-1:0]     cfg_ctx,
    output logic [ADDR_W-1:0]    cfg_pt,
    output logic [ADDR_W-1:0]    cfg_tex,
    output logic [ADDR_W-1:0]    cfg_pc,
    output logic                 fin_valid,
    output logic [SM_IDX_W-1:0]  fin_sm,
    output logic [KIDX_W-1:0]    fin_kern
);
    sm_entry_t   sm_q [SM_N];
    sm_entry_t   sm_d [SM_N];
    kern_entry_t kt   [KERN_N];
    kern_entry_t ld_ent;
    kern_entry_t gk;
    logic [SM_N-1:0]     need;
    logic                gv;
    logic [SM_IDX_W-1:0] gi;
    sm_entry_t           ge;
    logic                act_cfg, act_issue, act_fin;
    logic [SM_N*2-1:0]     st_flat;
    logic [SM_N*RUN_W-1:0] cnt_flat;

    assign ld_ent = '{pend: kld_blocks, lim: kld_limit, ctx: kld_ctx,
                      pt: kld_pt, tex: kld_tex, pc: kld_pc};

    // Service demand per core; a core named by this cycle's event waits.
    always_comb begin
        for (int i = 0; i < SM_N; i++) begin
            kern_entry_t e;
            e = kt[sm_q[i].kern];
            unique case (sm_q[i].st)
                SM_CFG:  need[i] = 1'b1;
                SM_RUN:  need[i] = (e.pend != '0 && sm_q[i].cnt < e.lim) ||
                                   (e.pend == '0 && sm_q[i].cnt == '0);
                SM_RESV: need[i] = (sm_q[i].cnt == '0);
                default: need[i] = 1'b0;
            endcase
            if (part_valid && int'(part_sm) == i) need[i] = 1'b0;
        end
    end

    blk_dispatch_arb #(.N(SM_N)) u_arb (
        .clk(clk), .rst(rst), .req(need), .gnt_valid(gv), .gnt_idx(gi)
    );

    assign ge        = sm_q[gi];
    assign gk        = kt[ge.kern];
    assign act_cfg   = gv && ge.st == SM_CFG;
    assign act_issue = gv && ge.st == SM_RUN && gk.pend != '0;
    assign act_fin   = gv && ge.st == SM_RUN && gk.pend == '0;

    blk_dispatch_ktable #(.KN(KERN_N)) u_ktab (
        .clk(clk), .rst(rst),
        .ld_valid(kld_valid), .ld_idx(kld_kern), .ld_ent(ld_ent),
        .dec_valid(act_issue), .dec_idx(ge.kern), .ents(kt)
    );

    // Next status entry per core: arbiter action, completions, partition event.
    always_comb begin
        for (int i = 0; i < SM_N; i++) begin
            logic mine, inc, dec;
            sm_d[i] = sm_q[i];
            mine = gv && int'(gi) == i;
            inc  = mine && act_issue;
            dec  = done_i[i] && sm_q[i].cnt != '0;
            sm_d[i].cnt = sm_q[i].cnt + RUN_W'(inc) - RUN_W'(dec);
            if (mine) begin
                unique case (sm_q[i].st)
                    SM_CFG:  sm_d[i].st = SM_RUN;
                    SM_RUN:  if (act_fin) sm_d[i].st = SM_IDLE;
                    SM_RESV: begin
                        sm_d[i].st   = SM_CFG;
                        sm_d[i].kern = sm_q[i].nxt;
                    end
                    default: ;
                endcase
            end
            if (part_valid && int'(part_sm) == i) begin
                if (!part_reserve && sm_q[i].st == SM_IDLE) begin
                    sm_d[i].st   = SM_CFG;
                    sm_d[i].kern = part_kern;
                end else if (part_reserve && sm_q[i].st == SM_RUN) begin
                    sm_d[i].st  = SM_RESV;
                    sm_d[i].nxt = part_kern;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SM_N; i++) begin
            if (rst) sm_q[i] <= '{st: SM_IDLE, kern: '0, nxt: '0, cnt: '0};
            else     sm_q[i] <= sm_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_valid <= 1'b0;
            cfg_valid   <= 1'b0;
            fin_valid   <= 1'b0;
            issue_sm    <= '0;
            issue_kern  <= '0;
            issue_blk   <= '0;
            cfg_sm      <= '0;
            cfg_ctx     <= '0;
            cfg_pt      <= '0;
            cfg_tex     <= '0;
            cfg_pc      <= '0;
            fin_sm      <= '0;
            fin_kern    <= '0;
        end else begin
            issue_valid <= act_issue;
            cfg_valid   <= act_cfg;
            fin_valid   <= act_fin;
            if (act_issue) begin
                issue_sm   <= gi;
                issue_kern <= ge.kern;
                issue_blk  <= gk.pend - 1'b1;
            end
            if (act_cfg) begin
                cfg_sm  <= gi;
                cfg_ctx <= gk.ctx;
                cfg_pt  <= gk.pt;
                cfg_tex <= gk.tex;
                cfg_pc  <= gk.pc;
            end
            if (act_fin) begin
                fin_sm   <= gi;
                fin_kern <= ge.kern;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SM_N; i++) begin
            st_flat[i*2 +: 2]          = sm_q[i].st;
            cnt_flat[i*RUN_W +: RUN_W] = sm_q[i].cnt;
        end
    end
endmodule

// File: rtl/blk_dispatch_chk.sv
module blk_dispatch_chk
    import blk_dispatch_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue_valid,
    input  logic [SM_IDX_W-1:0]    issue_sm,
    input  logic                   cfg_valid,
    input  logic [SM_IDX_W-1:0]    cfg_sm,
    input  logic                   fin_valid,
    input  logic [SM_IDX_W-1:0]    fin_sm,
    input  logic [SM_N-1:0]        done_i,
    input  logic [SM_N*2-1:0]      st_flat,
    input  logic [SM_N*RUN_W-1:0]  cnt_flat
);
    logic            rst_q;
    logic [SM_N-1:0] run_q, cfg_q, zero_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        for (int i = 0; i < SM_N; i++) begin
            if (rst) begin
                run_q[i]  <= 1'b0;
                cfg_q[i]  <= 1'b0;
                zero_q[i] <= 1'b1;
            end else begin
                run_q[i]  <= st_flat[i*2 +: 2] == 2'(SM_RUN);
                cfg_q[i]  <= st_flat[i*2 +: 2] == 2'(SM_CFG);
                zero_q[i] <= cnt_flat[i*RUN_W +: RUN_W] == '0;
            end
        end
    end

    // R1: outputs quiet right after a reset cycle
    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_quiet_R1: assert (!issue_valid && !cfg_valid && !fin_valid)
                else $error("R1 output active after reset");
        end
    end

    // R2 / R5 / R6: each action matches the core's state one cycle earlier
    always_ff @(posedge clk) begin
        if (!rst && !rst_q) begin
            if (cfg_valid)
                assert_cfg_from_setup_R2: assert (cfg_q[cfg_sm])
                    else $error("R2 setup pulse for core not awaiting setup");
            if (issue_valid)
                assert_issue_only_running_R6: assert (run_q[issue_sm])
                    else $error("R6 block issued to core not running");
            if (fin_valid)
                assert_fin_when_empty_R5: assert (zero_q[fin_sm])
                    else $error("R5 release with blocks in flight");
        end
    end

    assert_one_action_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({issue_valid, cfg_valid, fin_valid}))
        else $error("R7 more than one action in a cycle");

    genvar g;
    generate
        for (g = 0; g < SM_N; g++) begin : g_cnt
            assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
                done_i[g] |-> cnt_flat[g*RUN_W +: RUN_W] != '0)
                else $error("R8 completion with zero blocks in flight");
        end
    endgenerate
endmodule

bind blk_dispatch blk_dispatch_chk u_chk (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_sm(issue_sm),
    .cfg_valid(cfg_valid), .cfg_sm(cfg_sm),
    .fin_valid(fin_valid), .fin_sm(fin_sm),
    .done_i(done_i), .st_flat(st_flat), .cnt_flat(cnt_flat)
);

// File: tb/blk_dispatch_bench.sv
module blk_dispatch_bench;
    import blk_dispatch_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                 part_valid = 0, part_reserve = 0;
    logic [SM_IDX_W-1:0]  part_sm = '0;
    logic [KIDX_W-1:0]    part_kern = '0;
    logic [SM_N-1:0]      done_i = '0;
    logic                 kld_valid = 0;
    logic [KIDX_W-1:0]    kld_kern = '0;
    logic [BLK_W-1:0]     kld_blocks = '0;
    logic [RUN_W-1:0]     kld_limit = '0;
    logic [CTX_W-1:0]     kld_ctx = '0;
    logic [ADDR_W-1:0]    kld_pt = '0, kld_tex = '0, kld_pc = '0;
    logic                 issue_valid, cfg_valid, fin_valid;
    logic [SM_IDX_W-1:0]  issue_sm, cfg_sm, fin_sm;
    logic [KIDX_W-1:0]    issue_kern, fin_kern;
    logic [BLK_W-1:0]     issue_blk;
    logic [CTX_W-1:0]     cfg_ctx;
    logic [ADDR_W-1:0]    cfg_pt, cfg_tex, cfg_pc;

    blk_dispatch u_blk_dispatch (.*);

    // Behavioural reference: 0 idle, 1 setup, 2 running, 3 reserved
    int mst[SM_N], mk[SM_N], mnx[SM_N], mcnt[SM_N];
    int kp[KERN_N], kl[KERN_N], kc[KERN_N], kpt[KERN_N], ktx[KERN_N], kpc[KERN_N];
    int ptr;
    int e_iv, e_is, e_ik, e_ib, e_cv, e_cs, e_cc, e_cp, e_ct, e_cpc, e_fv, e_fs, e_fk;
    int checks = 0, fails = 0;
    int obs_issue[KERN_N], obs_fin[KERN_N], obs_cfg_sm0_ctx;
    string tag = "R1";
    int auto_done = 0;   // 0 none, 1 random, 2 all busy cores once
    bit finished = 0;

    always @(posedge clk) begin
        if (rst) begin
            ptr = 0;
            foreach (mst[i]) begin mst[i] = 0; mk[i] = 0; mnx[i] = 0; mcnt[i] = 0; end
            foreach (kp[i]) begin kp[i] = 0; kl[i] = 0; kc[i] = 0; kpt[i] = 0; ktx[i] = 0; kpc[i] = 0; end
            e_iv = 0; e_is = 0; e_ik = 0; e_ib = 0; e_cv = 0; e_cs = 0; e_cc = 0;
            e_cp = 0; e_ct = 0; e_cpc = 0; e_fv = 0; e_fs = 0; e_fk = 0;
        end else begin
            int win, incs;
            bit nd[SM_N];
            win = -1; incs = -1;
            for (int i = 0; i < SM_N; i++) begin
                case (mst[i])
                    1: nd[i] = 1;
                    2: nd[i] = (kp[mk[i]] > 0 && mcnt[i] < kl[mk[i]]) || (kp[mk[i]] == 0 && mcnt[i] == 0);
                    3: nd[i] = (mcnt[i] == 0);
                    default: nd[i] = 0;
                endcase
                if (part_valid && int'(part_sm) == i) nd[i] = 0;
            end
            for (int k = 0; k < SM_N; k++) begin
                if (win < 0 && nd[(ptr + k) % SM_N]) win = (ptr + k) % SM_N;
            end
            e_iv = 0; e_cv = 0; e_fv = 0;
            if (win >= 0) begin
                ptr = (win + 1) % SM_N;
                case (mst[win])
                    1: begin
                        e_cv = 1; e_cs = win; e_cc = kc[mk[win]]; e_cp = kpt[mk[win]];
                        e_ct = ktx[mk[win]]; e_cpc = kpc[mk[win]]; mst[win] = 2;
                    end
                    2: begin
                        if (kp[mk[win]] > 0) begin
                            e_iv = 1; e_is = win; e_ik = mk[win]; e_ib = kp[mk[win]] - 1;
                            kp[mk[win]]--; incs = win;
                        end else begin
                            e_fv = 1; e_fs = win; e_fk = mk[win]; mst[win] = 0;
                        end
                    end
                    3: begin mk[win] = mnx[win]; mst[win] = 1; end
                    default: ;
                endcase
            end
            for (int i = 0; i < SM_N; i++) begin
                if (incs == i) mcnt[i]++;
                if (done_i[i] && mcnt[i] > 0) mcnt[i]--;
            end
            if (part_valid) begin
                if (!part_reserve && mst[part_sm] == 0) begin mst[part_sm] = 1; mk[part_sm] = part_kern; end
                else if (part_reserve && mst[part_sm] == 2) begin mst[part_sm] = 3; mnx[part_sm] = part_kern; end
            end
            if (kld_valid) begin
                kp[kld_kern] = kld_blocks; kl[kld_kern] = kld_limit; kc[kld_kern] = kld_ctx;
                kpt[kld_kern] = kld_pt; ktx[kld_kern] = kld_tex; kpc[kld_kern] = kld_pc;
            end
        end
    end

    task automatic check(input string req, input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every cycle away from the edge, then pick completions.
    always @(negedge clk) begin
        if (!finished) begin
            check(tag, issue_valid == e_iv, "issue_valid", int'(issue_valid), e_iv);
            check(tag, cfg_valid == e_cv, "cfg_valid", int'(cfg_valid), e_cv);
            check(tag, fin_valid == e_fv, "fin_valid", int'(fin_valid), e_fv);
            if (e_iv && issue_valid)
                check(tag, int'(issue_sm) == e_is && int'(issue_kern) == e_ik && int'(issue_blk) == e_ib,
                      "issue sm*1000+kern*256+blk", int'(issue_sm)*1000 + int'(issue_kern)*256 + int'(issue_blk),
                      e_is*1000 + e_ik*256 + e_ib);
            if (e_cv && cfg_valid)
                check(tag, int'(cfg_sm) == e_cs && int'(cfg_ctx) == e_cc && int'(cfg_pt) == e_cp &&
                      int'(cfg_tex) == e_ct && int'(cfg_pc) == e_cpc, "cfg sm/ctx/pt/tex/pc (pt shown)",
                      int'(cfg_pt), e_cp);
            if (e_fv && fin_valid)
                check(tag, int'(fin_sm) == e_fs && int'(fin_kern) == e_fk, "fin sm*16+kern",
                      int'(fin_sm)*16 + int'(fin_kern), e_fs*16 + e_fk);
            if (issue_valid) obs_issue[issue_kern]++;
            if (fin_valid) obs_fin[fin_kern]++;
            if (cfg_valid && cfg_sm == 0) obs_cfg_sm0_ctx = int'(cfg_ctx);
        end
        for (int i = 0; i < SM_N; i++) begin
            if (auto_done == 1) done_i[i] = (mcnt[i] > 0) && ($urandom % 2 == 0);
            else if (auto_done == 2) done_i[i] = (mcnt[i] > 0);
            else done_i[i] = 1'b0;
        end
        if (auto_done == 2) auto_done = 0;
    end

    task automatic load_k(input int k, input int blocks, input int lim, input int ctx);
        @(negedge clk);
        kld_valid = 1; kld_kern = KIDX_W'(k); kld_blocks = BLK_W'(blocks); kld_limit = RUN_W'(lim);
        kld_ctx = CTX_W'(ctx); kld_pt = ADDR_W'(16'h1000 + k); kld_tex = ADDR_W'(16'h2000 + k);
        kld_pc = ADDR_W'(16'h3000 + k);
        @(negedge clk); kld_valid = 0;
    endtask

    task automatic part(input bit resv, input int sm, input int k);
        @(negedge clk);
        part_valid = 1; part_reserve = resv; part_sm = SM_IDX_W'(sm); part_kern = KIDX_W'(k);
        @(negedge clk); part_valid = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int k2_before;
        wait_cyc(3);
        check("R1", !issue_valid && !cfg_valid && !fin_valid, "outputs in reset", int'(issue_valid), 0);
        rst = 0;
        wait_cyc(2);
        tag = "R10";
        load_k(0, 6, 2, 5);
        load_k(1, 3, 3, 6);
        load_k(2, 2, 1, 7);
        load_k(3, 4, 4, 8);
        tag = "R2";
        part(0, 0, 0);
        part(0, 1, 0);
        tag = "R4";
        wait_cyc(10);
        check("R4", obs_issue[0] == 4, "k0 issues at limit", obs_issue[0], 4);
        tag = "R8";
        auto_done = 2;
        wait_cyc(5);
        check("R8", obs_issue[0] == 6, "k0 issues after dual completion", obs_issue[0], 6);
        tag = "R5";
        auto_done = 1;
        wait_cyc(40);
        check("R5", obs_fin[0] == 2, "k0 releases", obs_fin[0], 2);
        tag = "R7";
        part(0, 0, 1);
        part(0, 1, 2);
        part(0, 2, 3);
        part(0, 3, 1);
        wait_cyc(60);
        check("R7", obs_issue[1] == 3, "k1 issues", obs_issue[1], 3);
        check("R7", obs_issue[2] == 2, "k2 issues", obs_issue[2], 2);
        check("R7", obs_issue[3] == 4, "k3 issues", obs_issue[3], 4);
        check("R3", obs_fin[1] + obs_fin[2] + obs_fin[3] == 4, "releases", obs_fin[1] + obs_fin[2] + obs_fin[3], 4);
        auto_done = 0;
        tag = "R10";
        load_k(0, 20, 2, 9);
        load_k(2, 3, 1, 11);
        tag = "R9";
        part(0, 0, 0);
        wait_cyc(4);
        part(0, 0, 1);
        part(1, 1, 2);
        wait_cyc(4);
        check("R9", obs_issue[1] == 3, "k1 untouched by ignored assign", obs_issue[1], 3);
        tag = "R6";
        k2_before = obs_issue[2];
        part(1, 0, 2);
        auto_done = 1;
        wait_cyc(60);
        auto_done = 0;
        wait_cyc(4);
        check("R6", obs_issue[2] - k2_before == 3, "k2 issues after switch", obs_issue[2] - k2_before, 3);
        check("R6", obs_cfg_sm0_ctx == 11, "core0 reconfigured ctx", obs_cfg_sm0_ctx, 11);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule